// File: doc/BRIEF.md
# Exception vector resolver

This block decides which pending exception or interrupt the processor should service next. When the processor asks for a vector, the block returns that request's 16-bit vector address. Three reset causes map to fixed absolute addresses near the top of memory. Every other vector is formed relative to an 8-bit vector base: the base supplies the upper byte and a per-source offset supplies the lower byte.

The requests are resolved in a fixed order:

1. The resets.
2. The software exceptions.
3. The two access-violation requests.
4. The X-maskable line, then the I-maskable line.
5. A parameterised bank of maskable sources, each carrying its own priority level.

If nothing is still pending when the vector is fetched, a dedicated spurious vector is returned instead. The processor, the reset generator and the per-source priority registers live elsewhere. Their values arrive as plain inputs.

The request set is sampled on the clock edge where the fetch strobe is high. The chosen vector is registered and shown with a one-cycle valid pulse.

Top module: `exc_vector_resolver`

## Requirements
- R1: While any reset flag is high at a fetch, the vector is absolute and ignores both mask bits. The order is: power-on/pin/low-voltage/illegal-address reset gives 0xFFFE, then clock-monitor reset gives 0xFFFC, then watchdog reset gives 0xFFFA.
- R2: With no reset flag, fixed requests resolve as {vbase_i, offset} in this order: unimplemented-opcode trap 0xF8, SWI/debug 0xF6, system call 0x12, coprocessor access violation 0x16, CPU access violation 0x14, X-line 0xF4, I-line 0xF2.
- R3: Every fixed request of R2 (the I-line included, when not masked) outranks every source of the maskable bank, whatever that source's level.
- R4: Maskable source i has offset 0xF0 - 2*i. The pending source with the highest level wins. At equal level, the higher offset (lower index) wins. A level of 0 disables the source. Each source's level occupies bits [i*LVL_W +: LVL_W] of msk_lvl_i.
- R5: While xmask_i is 1, the X-line is ignored. While imask_i is 1, the I-line and the whole maskable bank are ignored.
- R6: When no request counts at the fetch edge, the output is the spurious vector {vbase_i, 0x10}. This includes requests that were dropped before the edge.
- R7: An output vector never has low byte 0x18, and its bit 0 is always 0.
- R8: A fetch sampled at edge k gives vec_valid_o high for exactly the cycle after k. Back-to-back fetches give back-to-back results. Without a fetch, vec_o holds its last value.
- R9: During reset, vec_o is 0 and vec_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_por_i | input | 1 | Power-on/pin/low-voltage/illegal-address reset cause |
| rst_clkmon_i | input | 1 | Clock-monitor reset cause |
| rst_wdog_i | input | 1 | Watchdog reset cause |
| req_trap_i | input | 1 | Unimplemented-opcode trap request |
| req_swi_i | input | 1 | Software interrupt / debug vector request |
| req_sys_i | input | 1 | System call request |
| req_cpviol_i | input | 1 | Coprocessor access violation request |
| req_cpuviol_i | input | 1 | CPU access violation request |
| xirq_i | input | 1 | X-maskable interrupt line |
| irq_i | input | 1 | I-maskable interrupt line |
| msk_req_i | input | NUM_SRC | Maskable source requests |
| msk_lvl_i | input | NUM_SRC*LVL_W | Packed per-source priority levels |
| imask_i | input | 1 | I mask bit |
| xmask_i | input | 1 | X mask bit |
| vbase_i | input | 8 | Vector base (upper address byte) |
| fetch_i | input | 1 | Vector fetch strobe |
| vec_o | output | 16 | Resolved vector address |
| vec_valid_o | output | 1 | Vector valid, one cycle per fetch |

## Verification
Mask filtering and priority resolution act in the same cycle. So does reset-vector override. A single fetch can therefore hold a reset cause, several fixed requests, both mask bits and maskable sources at once. The bench provokes this by raising many request lines together with set masks on one fetch edge. It judges the result against a scoreboard value computed from the ordering in R1 to R5. It also runs back-to-back fetches whose request sets differ, so that a new sample loads in the same cycle as the previous result is presented.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam logic [15:0] VEC_RST_POR    = 16'hFFFE;
  localparam logic [15:0] VEC_RST_CLKMON = 16'hFFFC;
  localparam logic [15:0] VEC_RST_WDOG   = 16'hFFFA;

  localparam logic [7:0] OFS_TRAP    = 8'hF8;
  localparam logic [7:0] OFS_SWI     = 8'hF6;
  localparam logic [7:0] OFS_SYS     = 8'h12;
  localparam logic [7:0] OFS_CPVIOL  = 8'h16;
  localparam logic [7:0] OFS_CPUVIOL = 8'h14;
  localparam logic [7:0] OFS_XIRQ    = 8'hF4;
  localparam logic [7:0] OFS_IRQ     = 8'hF2;
  localparam logic [7:0] OFS_MSK_TOP = 8'hF0;
  localparam logic [7:0] OFS_SPUR    = 8'h10;
  localparam logic [7:0] OFS_RSVD    = 8'h18;

  // Slots from 0xF0 down to 0x1A in steps of two
  localparam int MSK_SLOTS_MAX = 108;

  function automatic logic [15:0] rel_vec(input logic [7:0] base,
                                          input logic [7:0] ofs);
    return {base, ofs[7:1], 1'b0};
  endfunction

endpackage

// File: rtl/exc_rst_sync.sv
module exc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/exc_msk_arb.sv
module exc_msk_arb
  import exc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] lvl_i,
  input  logic                     imask_i,
  output logic                     hit_o,
  output logic [7:0]               ofs_o
);
  logic [LVL_W-1:0] eff_lvl [NUM_SRC];
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  // Qualify each source: masked or idle sources present level 0
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
    assign eff_lvl[g] = (req_i[g] && !imask_i) ? lvl_i[g*LVL_W +: LVL_W]
                                                : '0;
  end

  // Strictly-greater scan: lowest index (highest offset) keeps ties
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (eff_lvl[i] > best_lvl) begin
        best_lvl = eff_lvl[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign hit_o = (best_lvl != '0);
  assign ofs_o = OFS_MSK_TOP - 8'({best_idx, 1'b0});
endmodule

// File: rtl/exc_fixed_sel.sv
module exc_fixed_sel
  import exc_pkg::*;
(
  input  logic       rst_por_i,
  input  logic       rst_clkmon_i,
  input  logic       rst_wdog_i,
  input  logic       req_trap_i,
  input  logic       req_swi_i,
  input  logic       req_sys_i,
  input  logic       req_cpviol_i,
  input  logic       req_cpuviol_i,
  input  logic       xirq_i,
  input  logic       irq_i,
  input  logic       xmask_i,
  input  logic       imask_i,
  input  logic       msk_hit_i,
  input  logic [7:0] msk_ofs_i,
  input  logic [7:0] vbase_i,
  output logic [15:0] vec_o
);
  always_comb begin
    vec_o = rel_vec(vbase_i, OFS_SPUR);
    if      (rst_por_i)              vec_o = VEC_RST_POR;
    else if (rst_clkmon_i)           vec_o = VEC_RST_CLKMON;
    else if (rst_wdog_i)             vec_o = VEC_RST_WDOG;
    else if (req_trap_i)             vec_o = rel_vec(vbase_i, OFS_TRAP);
    else if (req_swi_i)              vec_o = rel_vec(vbase_i, OFS_SWI);
    else if (req_sys_i)              vec_o = rel_vec(vbase_i, OFS_SYS);
    else if (req_cpviol_i)           vec_o = rel_vec(vbase_i, OFS_CPVIOL);
    else if (req_cpuviol_i)          vec_o = rel_vec(vbase_i, OFS_CPUVIOL);
    else if (xirq_i && !xmask_i)     vec_o = rel_vec(vbase_i, OFS_XIRQ);
    else if (irq_i && !imask_i)      vec_o = rel_vec(vbase_i, OFS_IRQ);
    else if (msk_hit_i)              vec_o = rel_vec(vbase_i, msk_ofs_i);
  end
endmodule

// File: rtl/exc_vec_reg.sv
module exc_vec_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [15:0] vec_d_i,
  output logic [15:0] vec_o,
  output logic        valid_o
);
  logic [15:0] vec_q, vec_nxt;
  logic        val_q, val_nxt;

  always_comb begin
    vec_nxt = vec_q;
    if (load_i) vec_nxt = vec_d_i;
    val_nxt = load_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      val_q <= 1'b0;
    end else begin
      vec_q <= vec_nxt;
      val_q <= val_nxt;
    end
  end

  assign vec_o   = vec_q;
  assign valid_o = val_q;
endmodule

// File: rtl/exc_vector_resolver.sv
module exc_vector_resolver
  import exc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rst_por_i,
  input  logic                     rst_clkmon_i,
  input  logic                     rst_wdog_i,
  input  logic                     req_trap_i,
  input  logic                     req_swi_i,
  input  logic                     req_sys_i,
  input  logic                     req_cpviol_i,
  input  logic                     req_cpuviol_i,
  input  logic                     xirq_i,
  input  logic                     irq_i,
  input  logic [NUM_SRC-1:0]       msk_req_i,
  input  logic [NUM_SRC*LVL_W-1:0] msk_lvl_i,
  input  logic                     imask_i,
  input  logic                     xmask_i,
  input  logic [7:0]               vbase_i,
  input  logic                     fetch_i,
  output logic [15:0]              vec_o,
  output logic                     vec_valid_o
);
  // NUM_SRC must not exceed MSK_SLOTS_MAX so offsets stay above 0x18
  logic        rst_sync_n;
  logic        msk_hit;
  logic [7:0]  msk_ofs;
  logic [15:0] vec_d;

  exc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  exc_msk_arb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_msk_arb (
    .req_i   (msk_req_i),
    .lvl_i   (msk_lvl_i),
    .imask_i (imask_i),
    .hit_o   (msk_hit),
    .ofs_o   (msk_ofs)
  );

  exc_fixed_sel u_fixed_sel (
    .rst_por_i     (rst_por_i),
    .rst_clkmon_i  (rst_clkmon_i),
    .rst_wdog_i    (rst_wdog_i),
    .req_trap_i    (req_trap_i),
    .req_swi_i     (req_swi_i),
    .req_sys_i     (req_sys_i),
    .req_cpviol_i  (req_cpviol_i),
    .req_cpuviol_i (req_cpuviol_i),
    .xirq_i        (xirq_i),
    .irq_i         (irq_i),
    .xmask_i       (xmask_i),
    .imask_i       (imask_i),
    .msk_hit_i     (msk_hit),
    .msk_ofs_i     (msk_ofs),
    .vbase_i       (vbase_i),
    .vec_o         (vec_d)
  );

  exc_vec_reg u_vec_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (fetch_i),
    .vec_d_i (vec_d),
    .vec_o   (vec_o),
    .valid_o (vec_valid_o)
  );
endmodule

// File: rtl/exc_vector_resolver_chk.sv
module exc_vector_resolver_chk #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic                     rst_por_i,
  input logic                     rst_clkmon_i,
  input logic                     rst_wdog_i,
  input logic                     req_trap_i,
  input logic                     req_swi_i,
  input logic                     req_sys_i,
  input logic                     req_cpviol_i,
  input logic                     req_cpuviol_i,
  input logic                     xirq_i,
  input logic                     irq_i,
  input logic [NUM_SRC-1:0]       msk_req_i,
  input logic [NUM_SRC*LVL_W-1:0] msk_lvl_i,
  input logic                     imask_i,
  input logic                     xmask_i,
  input logic [7:0]               vbase_i,
  input logic                     fetch_i,
  input logic [15:0]              vec_o,
  input logic                     vec_valid_o
);
  logic [NUM_SRC-1:0] live;
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_live
    assign live[g] = msk_req_i[g] && (msk_lvl_i[g*LVL_W +: LVL_W] != '0);
  end

  logic any_rst, any_fixed, none_pending;
  assign any_rst   = rst_por_i | rst_clkmon_i | rst_wdog_i;
  assign any_fixed = req_trap_i | req_swi_i | req_sys_i | req_cpviol_i |
                     req_cpuviol_i | (xirq_i & !xmask_i) | (irq_i & !imask_i);
  assign none_pending = !any_rst && !any_fixed && !((|live) && !imask_i);

  // R8: valid follows a fetch by one cycle
  p_valid_after_fetch_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_i |=> vec_valid_o);
  p_no_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fetch_i |=> !vec_valid_o);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fetch_i |=> $stable(vec_o));

  // R1: reset causes give absolute vectors
  p_por_vec_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_i && rst_por_i) |=> (vec_o == 16'hFFFE));
  p_wdog_vec_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_i && rst_wdog_i && !rst_por_i && !rst_clkmon_i) |=> (vec_o == 16'hFFFA));

  // R3: trap outranks any maskable source
  p_trap_over_bank_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_i && !any_rst && req_trap_i) |=> (vec_o[7:0] == 8'hF8));

  // R6: spurious vector when nothing counts
  p_spurious_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fetch_i && none_pending) |=> (vec_o == {$past(vbase_i), 8'h10}));

  // R7: reserved low byte and odd addresses never appear
  p_no_reserved_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_valid_o |-> (vec_o[7:0] != 8'h18 && vec_o[0] == 1'b0));
endmodule

bind exc_vector_resolver exc_vector_resolver_chk #(
  .NUM_SRC(NUM_SRC), .LVL_W(LVL_W)
) u_chk (.*);

// File: tb/exc_vector_resolver_test.sv
`timescale 1ns/1ps
module exc_vector_resolver_test;
  localparam int NS = 8;
  localparam int LW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic rst_por_i, rst_clkmon_i, rst_wdog_i;
  logic req_trap_i, req_swi_i, req_sys_i, req_cpviol_i, req_cpuviol_i;
  logic xirq_i, irq_i, imask_i, xmask_i, fetch_i;
  logic [NS-1:0]    msk_req_i;
  logic [NS*LW-1:0] msk_lvl_i;
  logic [LW-1:0]    lvl_b [NS];
  logic [7:0]       vbase_i;
  logic [15:0]      vec_o;
  logic             vec_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic [15:0] last_exp;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) msk_lvl_i[i*LW +: LW] = lvl_b[i];
  end

  exc_vector_resolver #(.NUM_SRC(NS), .LVL_W(LW)) uut (.*);

  function automatic logic [15:0] model();
    int best = 0;
    int bi = -1;
    if (rst_por_i)    return 16'hFFFE;
    if (rst_clkmon_i) return 16'hFFFC;
    if (rst_wdog_i)   return 16'hFFFA;
    if (req_trap_i)    return {vbase_i, 8'hF8};
    if (req_swi_i)     return {vbase_i, 8'hF6};
    if (req_sys_i)     return {vbase_i, 8'h12};
    if (req_cpviol_i)  return {vbase_i, 8'h16};
    if (req_cpuviol_i) return {vbase_i, 8'h14};
    if (xirq_i && !xmask_i) return {vbase_i, 8'hF4};
    if (irq_i && !imask_i)  return {vbase_i, 8'hF2};
    if (!imask_i) begin
      for (int i = 0; i < NS; i++)
        if (msk_req_i[i] && int'(lvl_b[i]) > best) begin
          best = int'(lvl_b[i]);
          bi = i;
        end
    end
    if (bi >= 0) return {vbase_i, 8'(240 - 2*bi)};
    return {vbase_i, 8'h10};
  endfunction

  task automatic clear_in();
    rst_por_i = 0; rst_clkmon_i = 0; rst_wdog_i = 0;
    req_trap_i = 0; req_swi_i = 0; req_sys_i = 0;
    req_cpviol_i = 0; req_cpuviol_i = 0;
    xirq_i = 0; irq_i = 0; imask_i = 0; xmask_i = 0;
    msk_req_i = '0;
    for (int i = 0; i < NS; i++) lvl_b[i] = '0;
  endtask

  // Driver: caller sets inputs at a falling edge, then calls this
  task automatic fetch_now(input string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
    last_exp = model();
    fetch_i = 1'b1;
    @(negedge clk);
    fetch_i = 1'b0;
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n && vec_valid_o) begin
        if (exp_q.size() == 0) begin
          check("R8 unexpected valid", 16'd1, 16'd0);
        end else begin
          automatic logic [15:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, vec_o, e);
          check("R7 reserved/odd", {15'd0, (vec_o[7:0] == 8'h18) || vec_o[0]}, 16'd0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_i = 1'b0;
    vbase_i = 8'hC3;
    clear_in();
    repeat (3) @(negedge clk);
    check("R9 vec_o in reset", vec_o, 16'h0000);
    check("R9 valid in reset", {15'd0, vec_valid_o}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset causes, masks set, everything else pending
    rst_por_i = 1; rst_clkmon_i = 1; rst_wdog_i = 1; req_trap_i = 1;
    xirq_i = 1; irq_i = 1; imask_i = 1; xmask_i = 1;
    fetch_now("R1 por");
    rst_por_i = 0;
    fetch_now("R1 clkmon");
    rst_clkmon_i = 0;
    fetch_now("R1 wdog");
    clear_in();

    // R2: walk down the fixed order, each step with all lower ones pending
    req_trap_i = 1; req_swi_i = 1; req_sys_i = 1; req_cpviol_i = 1;
    req_cpuviol_i = 1; xirq_i = 1; irq_i = 1;
    msk_req_i = '1; lvl_b[0] = 3'd7;
    fetch_now("R2 trap");
    req_trap_i = 0;    fetch_now("R2 swi");
    req_swi_i = 0;     fetch_now("R2 sys");
    req_sys_i = 0;     fetch_now("R2 cpviol");
    req_cpviol_i = 0;  fetch_now("R2 cpuviol");
    req_cpuviol_i = 0; fetch_now("R2 xirq");
    xirq_i = 0;        fetch_now("R3 irq over bank");
    irq_i = 0;
    vbase_i = 8'h5A;
    req_cpuviol_i = 1; fetch_now("R3 viol over bank");
    clear_in();

    // R4: level and tie rules
    msk_req_i = 8'b0100_1000; lvl_b[3] = 3'd5; lvl_b[6] = 3'd7;
    fetch_now("R4 highest level");
    clear_in();
    msk_req_i = 8'b0010_0100; lvl_b[2] = 3'd4; lvl_b[5] = 3'd4;
    fetch_now("R4 tie higher offset");
    clear_in();
    msk_req_i = 8'b1000_0001; lvl_b[0] = 3'd0; lvl_b[7] = 3'd1;
    fetch_now("R4 level0 disabled, last slot");
    clear_in();
    msk_req_i = '1;
    fetch_now("R6 all level0");

    // R5: mask bits
    clear_in();
    xirq_i = 1; xmask_i = 1;
    fetch_now("R5 xirq masked");
    irq_i = 1;
    fetch_now("R5 xirq masked irq wins");
    clear_in();
    irq_i = 1; imask_i = 1; msk_req_i = 8'h01; lvl_b[0] = 3'd7;
    fetch_now("R5 imask blocks irq and bank");
    xirq_i = 1;
    fetch_now("R5 imask keeps xirq");
    clear_in();

    // R6: request withdrawn before the fetch edge
    vbase_i = 8'h81;
    irq_i = 1;
    @(negedge clk);
    irq_i = 0;
    fetch_now("R6 withdrawn");

    // R8: back-to-back fetches with different sets, then hold
    req_sys_i = 1;
    exp_q.push_back(model()); tag_q.push_back("R8 b2b first");
    fetch_i = 1'b1;
    @(negedge clk);
    req_sys_i = 0; msk_req_i = 8'h10; lvl_b[4] = 3'd2;
    fetch_now("R8 b2b second");
    rst_por_i = 1; req_trap_i = 1; vbase_i = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 hold vec_o", vec_o, last_exp);
    check("R8 valid low idle", {15'd0, vec_valid_o}, 16'h0000);
    clear_in();

    repeat (3) @(negedge clk);
    check("R8 queue drained", 16'(exp_q.size()), 16'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule